// File: doc/BRIEF.md
# Thermal Voltage Level Controller

This block selects a supply-voltage level from a small fixed set, based on temperature samples it evaluates on its own programmable interval. A critical set point drives the level one step down when the chip runs hot, and one step up when it has thermal headroom. A separate, higher power-down threshold overrides the stepping: it forces the lowest level and raises a shutdown indication at once, without waiting for a sample tick.

Every ordinary level change runs through a handshake with the pipeline. The block first requests a flush and stalls. It holds the old level until the pipeline acknowledges that the flush is complete. It then presents the new level to the regulator, together with a one-cycle update strobe and the base-frequency code for that level. It keeps the stall asserted for a programmable settle time before releasing it. The frequency code goes to a downstream frequency controller, which may trim around it.

Top module: `thermal_vlevel_ctrl`

## Requirements
- R1: After reset the level is 0, the frequency code is that of level 0, and flush, stall, update and shutdown outputs are low.
- R2: At a sample tick with temperature strictly above the critical threshold and level above 0, the level is lowered by exactly one.
- R3: At a sample tick with temperature strictly below the critical threshold and level below the top level (NUM_LEVELS-1), the level is raised by exactly one; a temperature equal to the threshold leaves the level unchanged.
- R4: The level saturates at 0 and at the top level; no flush sequence starts at a tick when the requested step is blocked by saturation.
- R5: The frequency code equals FREQ_BASE + level*FREQ_STEP (40 + 20*level by default). The update strobe pulses high for exactly one cycle, in the cycle the new level first appears.
- R6: A level change starts with flush and stall rising together. Flush stays high and the level stays unchanged until the flush-done input is seen. A flush-done input while no change is pending has no effect.
- R7: After flush-done, flush falls. Stall remains high for exactly settle_i+1 cycles, then falls.
- R8: When the temperature is at or above the power-down threshold in any cycle, in the next cycle shutdown is high, the level is 0, and flush and stall are low, which aborts any sequence in progress.
- R9: Shutdown stays high until the temperature falls strictly below the critical threshold. No stepping occurs while shutdown is high.
- R10: Sample ticks are spaced interval_i+1 cycles apart while idle, counted from the first idle cycle. Consequently, when a step is due, flush rises interval_i+1 cycles after stall falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| temp_i | input | TEMP_W | Current temperature sample |
| crit_thr_i | input | TEMP_W | Critical set point |
| pdown_thr_i | input | TEMP_W | Power-down threshold |
| interval_i | input | INTV_W | Sample spacing minus one, in cycles |
| settle_i | input | SETTLE_W | Settle length minus one, in cycles |
| flush_done_i | input | 1 | Pipeline flush acknowledge |
| vlevel_o | output | LVL_W | Voltage level index to regulator |
| vlevel_upd_o | output | 1 | One-cycle strobe on a new level |
| freq_code_o | output | FREQ_W | Base-frequency code for the level |
| flush_o | output | 1 | Pipeline flush request |
| stall_o | output | 1 | Pipeline stall |
| shutdown_o | output | 1 | Power-down indication |

## Verification
The hardest case to reach is a power-down event that lands in the middle of a flush handshake. It has to abort the sequence cleanly, not complete it at level 0. The bench reaches this case by holding the temperature below the set point until flush rises. It then withholds the acknowledge and raises the temperature past the power-down threshold, so that the abort occurs while the change is still pending. The exact tick spacing is also hard to see from outside, because the sample timer is free-running. The bench measures it from the release of stall, where the timer is known to restart.

// File: rtl/tvc_pkg.sv
package tvc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FLUSH  = 2'd1,
    ST_SETTLE = 2'd2
  } tvc_state_e;
endpackage

// File: rtl/tvc_sample_timer.sv
module tvc_sample_timer #(
  parameter int INTV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [INTV_W-1:0] interval_i,
  output logic              tick_o
);
  logic [INTV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == interval_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  AST_TIMER_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !tick_o || (interval_i == '0)) else $error("timer restart"); // R10
endmodule

// File: rtl/tvc_freq_lut.sv
module tvc_freq_lut #(
  parameter int NUM_LEVELS = 4,
  parameter int LVL_W      = 2,
  parameter int FREQ_W     = 8,
  parameter int FREQ_BASE  = 40,
  parameter int FREQ_STEP  = 20
) (
  input  logic [LVL_W-1:0]  level_i,
  output logic [FREQ_W-1:0] freq_o
);
  logic [FREQ_W-1:0] tbl [NUM_LEVELS];

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_tbl
    assign tbl[g] = FREQ_W'(FREQ_BASE + g * FREQ_STEP);
  end

  assign freq_o = tbl[level_i];
endmodule

// File: rtl/tvc_step_seq.sv
module tvc_step_seq
  import tvc_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  parameter int LVL_W      = 2,
  parameter int TEMP_W     = 8,
  parameter int SETTLE_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [TEMP_W-1:0]   temp_i,
  input  logic [TEMP_W-1:0]   crit_thr_i,
  input  logic [TEMP_W-1:0]   pdown_thr_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                flush_done_i,
  output logic                run_o,
  output logic [LVL_W-1:0]    level_o,
  output logic                upd_o,
  output logic                flush_o,
  output logic                stall_o,
  output logic                shutdown_o
);
  localparam logic [LVL_W-1:0] MAX_LVL = LVL_W'(NUM_LEVELS - 1);

  tvc_state_e          state_q;
  logic [LVL_W-1:0]    level_q, target_q;
  logic [SETTLE_W-1:0] cnt_q;
  logic                upd_q, shut_q;
  logic                hot, warm, cool;

  always_comb begin
    hot  = temp_i >= pdown_thr_i;
    warm = temp_i >  crit_thr_i;
    cool = temp_i <  crit_thr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      level_q  <= '0;
      target_q <= '0;
      cnt_q    <= '0;
      upd_q    <= 1'b0;
      shut_q   <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (hot) begin
        // power-down overrides everything, including a pending change
        shut_q  <= 1'b1;
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        if (level_q != '0) begin
          level_q <= '0;
          upd_q   <= 1'b1;
        end
      end else begin
        if (cool) shut_q <= 1'b0;
        unique case (state_q)
          ST_IDLE: begin
            if (tick_i && !shut_q) begin
              if (warm && level_q != '0) begin
                target_q <= level_q - 1'b1;
                state_q  <= ST_FLUSH;
              end else if (cool && level_q != MAX_LVL) begin
                target_q <= level_q + 1'b1;
                state_q  <= ST_FLUSH;
              end
            end
          end
          ST_FLUSH: begin
            if (flush_done_i) begin
              level_q <= target_q;
              upd_q   <= 1'b1;
              cnt_q   <= '0;
              state_q <= ST_SETTLE;
            end
          end
          ST_SETTLE: begin
            if (cnt_q == settle_i) state_q <= ST_IDLE;
            else                   cnt_q   <= cnt_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign run_o      = (state_q == ST_IDLE) && !shut_q;
  assign level_o    = level_q;
  assign upd_o      = upd_q;
  assign flush_o    = (state_q == ST_FLUSH);
  assign stall_o    = (state_q != ST_IDLE);
  assign shutdown_o = shut_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= MAX_LVL) else $error("level overflow"); // R4
  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q != $past(level_q)) |->
      (level_q == '0 || level_q == $past(level_q) + 1'b1 || level_q == $past(level_q) - 1'b1))
    else $error("multi step"); // R2
  AST_FLUSH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && !flush_done_i && !hot) |=> (flush_o && $stable(level_q)))
    else $error("flush dropped"); // R6
  AST_FLUSH_IN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> stall_o) else $error("flush without stall"); // R6
  AST_PDOWN_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hot |=> (shutdown_o && level_q == '0 && !stall_o)) else $error("power-down"); // R8
  AST_SHUT_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutdown_o && $past(shutdown_o)) |-> (level_q == '0)) else $error("step in shutdown"); // R9
endmodule

// File: rtl/thermal_vlevel_ctrl.sv
module thermal_vlevel_ctrl #(
  parameter int NUM_LEVELS = 4,
  parameter int TEMP_W     = 8,
  parameter int INTV_W     = 16,
  parameter int SETTLE_W   = 8,
  parameter int FREQ_W     = 8,
  parameter int FREQ_BASE  = 40,
  parameter int FREQ_STEP  = 20,
  localparam int LVL_W     = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TEMP_W-1:0]   temp_i,
  input  logic [TEMP_W-1:0]   crit_thr_i,
  input  logic [TEMP_W-1:0]   pdown_thr_i,
  input  logic [INTV_W-1:0]   interval_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                flush_done_i,
  output logic [LVL_W-1:0]    vlevel_o,
  output logic                vlevel_upd_o,
  output logic [FREQ_W-1:0]   freq_code_o,
  output logic                flush_o,
  output logic                stall_o,
  output logic                shutdown_o
);
  logic run, tick;

  tvc_sample_timer #(.INTV_W(INTV_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .interval_i (interval_i),
    .tick_o     (tick)
  );

  tvc_step_seq #(
    .NUM_LEVELS (NUM_LEVELS),
    .LVL_W      (LVL_W),
    .TEMP_W     (TEMP_W),
    .SETTLE_W   (SETTLE_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .temp_i       (temp_i),
    .crit_thr_i   (crit_thr_i),
    .pdown_thr_i  (pdown_thr_i),
    .settle_i     (settle_i),
    .flush_done_i (flush_done_i),
    .run_o        (run),
    .level_o      (vlevel_o),
    .upd_o        (vlevel_upd_o),
    .flush_o      (flush_o),
    .stall_o      (stall_o),
    .shutdown_o   (shutdown_o)
  );

  tvc_freq_lut #(
    .NUM_LEVELS (NUM_LEVELS),
    .LVL_W      (LVL_W),
    .FREQ_W     (FREQ_W),
    .FREQ_BASE  (FREQ_BASE),
    .FREQ_STEP  (FREQ_STEP)
  ) u_lut (
    .level_i (vlevel_o),
    .freq_o  (freq_code_o)
  );
endmodule

// File: tb/thermal_vlevel_ctrl_tb.sv
module thermal_vlevel_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] temp_i = 8'd80;
  logic [7:0] crit_thr_i = 8'd80;
  logic [7:0] pdown_thr_i = 8'd105;
  logic [15:0] interval_i = 16'd3;
  logic [7:0] settle_i = 8'd2;
  logic       flush_done_i = 1'b0;
  logic [1:0] vlevel_o;
  logic       vlevel_upd_o;
  logic [7:0] freq_code_o;
  logic       flush_o, stall_o, shutdown_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  thermal_vlevel_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .temp_i(temp_i), .crit_thr_i(crit_thr_i),
    .pdown_thr_i(pdown_thr_i), .interval_i(interval_i), .settle_i(settle_i),
    .flush_done_i(flush_done_i), .vlevel_o(vlevel_o), .vlevel_upd_o(vlevel_upd_o),
    .freq_code_o(freq_code_o), .flush_o(flush_o), .stall_o(stall_o),
    .shutdown_o(shutdown_o)
  );

  // temperature, expected level after the step, requirement exercised
  localparam int NV = 10;
  localparam int VT [NV] = '{50, 50, 50, 50, 80, 90, 90, 90, 90, 79};
  localparam int VL [NV] = '{ 1,  2,  3,  3,  3,  2,  1,  0,  0,  1};
  localparam int VR [NV] = '{ 3,  3,  3,  4,  3,  2,  2,  2,  4,  3};

  function automatic string rname(int r);
    case (r)
      2: return "R2";
      3: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // apply a temperature and follow one step (or none) to completion
  task automatic do_step(int t, int exp_lvl, string req);
    int n, upd, st, prev;
    prev = vlevel_o;
    temp_i = 8'(t);
    n = 0;
    while (!flush_o && n < 2 * (int'(interval_i) + 1) + 4) begin
      @(negedge clk_i); n++;
    end
    if (flush_o) begin
      chk(stall_o, "R6", stall_o, 1);
      repeat (4) @(negedge clk_i);
      chk(flush_o && vlevel_o == prev, "R6", vlevel_o, prev);
      flush_done_i = 1'b1;
      @(negedge clk_i);
      flush_done_i = 1'b0;
      upd = 0; st = 0;
      while (stall_o && st < 300) begin
        if (vlevel_upd_o) upd++;
        if (flush_o) chk(0, "R7", 1, 0);
        st++;
        @(negedge clk_i);
      end
      chk(st == int'(settle_i) + 1, "R7", st, int'(settle_i) + 1);
      chk(upd == 1, "R5", upd, 1);
    end
    chk(vlevel_o == 2'(exp_lvl), req, vlevel_o, exp_lvl);
    chk(freq_code_o == 8'(40 + 20 * exp_lvl), "R5", freq_code_o, 40 + 20 * exp_lvl);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(vlevel_o == 0 && freq_code_o == 40, "R1", freq_code_o, 40);
    chk(!flush_o && !stall_o && !shutdown_o && !vlevel_upd_o, "R1", flush_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      bit flushed;
      if (VR[i] == 4 || VT[i] == 80) begin
        // no step expected: flush must never rise (R4, R3 hold)
        temp_i = 8'(VT[i]);
        flushed = 0;
        repeat (2 * (int'(interval_i) + 1) + 4) begin
          @(negedge clk_i);
          if (flush_o) flushed = 1;
        end
        chk(!flushed, rname(VR[i]), flushed, 0);
        chk(vlevel_o == 2'(VL[i]), rname(VR[i]), vlevel_o, VL[i]);
      end else begin
        do_step(VT[i], VL[i], rname(VR[i]));
      end
    end

    // R6 flush-done while idle is ignored
    temp_i = 8'd80;
    repeat (6) @(negedge clk_i);
    flush_done_i = 1'b1;
    repeat (3) @(negedge clk_i);
    flush_done_i = 1'b0;
    @(negedge clk_i);
    chk(vlevel_o == 1 && !stall_o && !vlevel_upd_o, "R6", vlevel_o, 1);

    // R10 tick spacing measured from release of stall, R7 with longer settle
    interval_i = 16'd6;
    settle_i = 8'd5;
    do_step(50, 2, "R3");
    n = 0;
    while (!flush_o && n < 50) begin
      @(negedge clk_i); n++;
    end
    chk(n == 7, "R10", n, 7);
    flush_done_i = 1'b1;
    @(negedge clk_i);
    flush_done_i = 1'b0;
    n = 0;
    while (stall_o && n < 50) begin
      @(negedge clk_i); n++;
    end
    chk(n == 6, "R7", n, 6);
    chk(vlevel_o == 3, "R3", vlevel_o, 3);

    // R8 power-down from the top level
    temp_i = 8'd80;
    repeat (3) @(negedge clk_i);
    temp_i = 8'd110;
    @(negedge clk_i);
    chk(shutdown_o && vlevel_o == 0 && !stall_o, "R8", vlevel_o, 0);
    chk(freq_code_o == 40, "R8", freq_code_o, 40);
    repeat (20) @(negedge clk_i);
    chk(vlevel_o == 0 && !flush_o, "R9", vlevel_o, 0);
    // R9 between the thresholds shutdown is held
    temp_i = 8'd90;
    repeat (20) @(negedge clk_i);
    chk(shutdown_o && !stall_o, "R9", shutdown_o, 1);
    temp_i = 8'd50;
    @(negedge clk_i);
    chk(!shutdown_o, "R9", shutdown_o, 0);
    do_step(50, 1, "R9");

    // R8 abort in the middle of a flush handshake
    n = 0;
    while (!flush_o && n < 50) begin
      @(negedge clk_i); n++;
    end
    chk(flush_o && vlevel_o == 1, "R6", vlevel_o, 1);
    temp_i = 8'd120;
    @(negedge clk_i);
    chk(!flush_o && !stall_o && shutdown_o, "R8", stall_o, 0);
    chk(vlevel_o == 0, "R8", vlevel_o, 0);
    flush_done_i = 1'b1;
    @(negedge clk_i);
    flush_done_i = 1'b0;
    @(negedge clk_i);
    chk(vlevel_o == 0 && !stall_o, "R8", vlevel_o, 0);
    temp_i = 8'd50;
    @(negedge clk_i);
    do_step(50, 1, "R3");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule